// File: doc/BRIEF.md
# Control-Line Arithmetic-Logic Datapath

This block is a purely combinational 8-bit arithmetic-logic datapath with no opcode decoder. Eight independent control lines act directly on one ripple full-adder chain. Two lines invert the operand words, one suppresses every carry, one suppresses the shared AND term, one feeds the chain's carry input, one inverts the final word, and two select a one-bit logical shift of operand A. Each function in the instruction repertoire is a fixed pattern of these lines, so a sequencer can drive the block straight from an instruction field.

Besides the result word, the block exports the ripple carry out of the top bit, the carry out of the low nibble and the carry into the most significant bit. A separate flag unit uses these to form the carry, half-carry and signed-overflow flags. When a function uses only one operand, the other operand is gated to zero inside the block, so the result does not depend on it.

Top module: `ctl_alu`

## Requirements
- R1: With every control line low, res = (opa + opb) mod 256. carry_out is bit 8 of the sum, half_carry is 1 when (opa mod 16)+(opb mod 16) > 15, and carry_to_msb is 1 when (opa mod 128)+(opb mod 128) > 127.
- R2: With only kill_carry high, res = opa XOR opb.
- R3: With only kill_and high, res = opa OR opb. With kill_and, inv_a and inv_b high, res = NOT(opa AND opb). In both cases carry_out, half_carry and carry_to_msb are 0.
- R4: inv_res inverts the final word. Alone it gives NOT(opa+opb) with the same carries as R1. With kill_carry it gives XNOR. With kill_and it gives NOR. With kill_and, inv_a and inv_b it gives AND, and in the last two cases all carries are 0.
- R5: With only carry_in high, res = (opa + 1) mod 256 whatever opb is. carry_out is 1 exactly when opa = 255, half_carry when opa mod 16 = 15, and carry_to_msb when opa mod 128 = 127.
- R6: With carry_in and inv_b high (subtract and compare), res = (opa − opb) mod 256. carry_out is 1 exactly when opa ≥ opb, and half_carry is 1 exactly when opa mod 16 ≥ opb mod 16.
- R7: With only inv_a high, res = NOT opa whatever opb is. With only inv_b high, res = NOT opb whatever opa is. All carries are 0.
- R8: With shr high and shl low, res = opa >> 1 (zero in bit 7) and carry_out = opa bit 0. With shl high and shr low, res = opa << 1 (zero in bit 0) and carry_out = opa bit 7. The other six lines have no effect while a shift is selected.
- R9: With shr and shl both high, res = opa and carry_out = 0. Whenever shr or shl is high, half_carry and carry_to_msb are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | 8 | Operand word A |
| opb | input | 8 | Operand word B |
| inv_a | input | 1 | Invert operand A |
| inv_b | input | 1 | Invert operand B |
| kill_carry | input | 1 | Suppress all carries in the chain |
| kill_and | input | 1 | Suppress the shared AND (generate) term |
| carry_in | input | 1 | Carry into bit 0 |
| inv_res | input | 1 | Invert the final word |
| shr | input | 1 | Logical right shift of opa by one |
| shl | input | 1 | Logical left shift of opa by one |
| res | output | 8 | Result word |
| carry_out | output | 1 | Carry out of the top bit, or the bit shifted out |
| half_carry | output | 1 | Carry out of bit 3 |
| carry_to_msb | output | 1 | Carry into bit 7 |

## Verification
The immediate assertions assume that the control lines and operands are settled, known values whenever the combinational logic is evaluated. They also assume that the control patterns they test (plain add, single-bit shifts, both shifts) are applied as whole patterns and not as partial mixtures. The bench drives the lines only as complete 8-bit codes from the function table and a few fixed shift-override patterns, and never leaves an X or Z on any input. Each of the fourteen codes is swept over all 65536 operand pairs, and outputs are sampled after the inputs have settled.

// File: rtl/alu_pkg.sv
package alu_pkg;

   localparam int unsigned ALU_W_DEF   = 8;
   localparam int unsigned ALU_NIB_DEF = 4;

   typedef enum logic [1:0] {
      SH_NONE  = 2'b00,
      SH_RIGHT = 2'b01,
      SH_LEFT  = 2'b10,
      SH_HOLD  = 2'b11
   } shmode_t;

endpackage

// File: rtl/alu_operand_gate.sv
module alu_operand_gate #(
   parameter int unsigned W = alu_pkg::ALU_W_DEF
) (
   input  logic [W-1:0] a_in,
   input  logic [W-1:0] b_in,
   input  logic         inv_a,
   input  logic         inv_b,
   input  logic         kill_and,
   input  logic         carry_in,
   output logic [W-1:0] a_out,
   output logic [W-1:0] b_out
);

   logic zero_a;
   logic zero_b;
   logic [W-1:0] a_g;
   logic [W-1:0] b_g;

   // unused operand forced to zero for NOT A, NOT B and increment
   assign zero_b = ~inv_b & ~kill_and & (inv_a | carry_in);
   assign zero_a = inv_b & ~inv_a & ~carry_in & ~kill_and;

   assign a_g   = zero_a ? '0 : a_in;
   assign b_g   = zero_b ? '0 : b_in;
   assign a_out = inv_a ? ~a_g : a_g;
   assign b_out = inv_b ? ~b_g : b_g;

   always_comb begin
      if (inv_a && !inv_b && !kill_and && !carry_in)
         assert_nota_indep_R7: assert (b_out == '0)
            else $error("operand B leaks into NOT A");
      if (carry_in && !inv_b && !inv_a && !kill_and)
         assert_inc_indep_R5: assert (b_out == '0 && a_out == a_in)
            else $error("increment operands wrong");
   end

endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice (
   input  logic a,
   input  logic b,
   input  logic ci,
   input  logic kill_carry,
   input  logic kill_and,
   output logic s,
   output logic co
);

   logic and_t;
   logic prop;
   logic ci_eff;

   assign and_t  = a & b & ~kill_and;
   assign prop   = (a | b) & ~and_t;
   assign ci_eff = ci & ~kill_carry;
   assign s      = prop ^ ci_eff;
   assign co     = and_t | (prop & ci_eff);

   always_comb begin
      if (kill_and && !ci)
         assert_or_slice_R3: assert (s == (a | b) && co == 1'b0)
            else $error("slice OR mode wrong");
   end

endmodule

// File: rtl/alu_shift_unit.sv
module alu_shift_unit #(
   parameter int unsigned W = alu_pkg::ALU_W_DEF
) (
   input  logic [W-1:0]     opa,
   input  alu_pkg::shmode_t mode,
   output logic [W-1:0]     sh_res,
   output logic             sh_out,
   output logic             active
);

   import alu_pkg::*;

   always_comb begin
      sh_res = opa;
      sh_out = 1'b0;
      active = 1'b1;
      unique case (mode)
         SH_RIGHT: begin
            sh_res = {1'b0, opa[W-1:1]};
            sh_out = opa[0];
         end
         SH_LEFT: begin
            sh_res = {opa[W-2:0], 1'b0};
            sh_out = opa[W-1];
         end
         SH_HOLD: begin
            sh_res = opa;
            sh_out = 1'b0;
         end
         default: active = 1'b0;
      endcase
   end

   always_comb begin
      if (mode == SH_RIGHT)
         assert_shr_fill_R8: assert (sh_res[W-1] == 1'b0 && sh_out == opa[0])
            else $error("right shift fill wrong");
      if (mode == SH_LEFT)
         assert_shl_fill_R8: assert (sh_res[0] == 1'b0 && sh_out == opa[W-1])
            else $error("left shift fill wrong");
   end

endmodule

// File: rtl/ctl_alu.sv
module ctl_alu #(
   parameter int unsigned WIDTH  = alu_pkg::ALU_W_DEF,
   parameter int unsigned NIBBLE = alu_pkg::ALU_NIB_DEF
) (
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   input  logic             inv_a,
   input  logic             inv_b,
   input  logic             kill_carry,
   input  logic             kill_and,
   input  logic             carry_in,
   input  logic             inv_res,
   input  logic             shr,
   input  logic             shl,
   output logic [WIDTH-1:0] res,
   output logic             carry_out,
   output logic             half_carry,
   output logic             carry_to_msb
);

   import alu_pkg::*;

   localparam int unsigned MSB = WIDTH - 1;

   if (WIDTH < 2) begin : g_chk_w
      $error("WIDTH must be at least 2");
   end
   if (NIBBLE < 1 || NIBBLE >= WIDTH) begin : g_chk_n
      $error("NIBBLE must lie inside the word");
   end

   logic [WIDTH-1:0] a_op;
   logic [WIDTH-1:0] b_op;
   logic [WIDTH-1:0] sum;
   logic [WIDTH:0]   cy;
   logic [WIDTH-1:0] sh_res;
   logic             sh_out;
   logic             sh_act;
   shmode_t          mode;

   alu_operand_gate #(.W(WIDTH)) u_gate (
      .a_in     (opa),
      .b_in     (opb),
      .inv_a    (inv_a),
      .inv_b    (inv_b),
      .kill_and (kill_and),
      .carry_in (carry_in),
      .a_out    (a_op),
      .b_out    (b_op)
   );

   assign cy[0] = carry_in;

   for (genvar i = 0; i < WIDTH; i++) begin : g_slice
      alu_bit_slice u_bit (
         .a          (a_op[i]),
         .b          (b_op[i]),
         .ci         (cy[i]),
         .kill_carry (kill_carry),
         .kill_and   (kill_and),
         .s          (sum[i]),
         .co         (cy[i+1])
      );
   end

   assign mode = shmode_t'({shl, shr});

   alu_shift_unit #(.W(WIDTH)) u_shift (
      .opa    (opa),
      .mode   (mode),
      .sh_res (sh_res),
      .sh_out (sh_out),
      .active (sh_act)
   );

   always_comb begin
      if (sh_act) begin
         res          = sh_res;
         carry_out    = sh_out;
         half_carry   = 1'b0;
         carry_to_msb = 1'b0;
      end else begin
         res          = inv_res ? ~sum : sum;
         carry_out    = cy[WIDTH];
         half_carry   = cy[NIBBLE];
         carry_to_msb = cy[MSB];
      end
   end

   always_comb begin
      if ({inv_a, inv_b, kill_carry, kill_and, carry_in, inv_res, shr, shl} == 8'h00)
         assert_add_sum_R1: assert ({carry_out, res} == ({1'b0, opa} + {1'b0, opb}))
            else $error("plain add result wrong");
      if (shr && shl)
         assert_hold_R9: assert (res == opa && !carry_out && !half_carry && !carry_to_msb)
            else $error("double shift did not hold A");
   end

endmodule

// File: tb/ctl_alu_tb.sv
`timescale 1ns/100ps
module ctl_alu_tb;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic [7:0] opa, opb;
   logic inv_a, inv_b, kill_carry, kill_and, carry_in, inv_res, shr, shl;
   logic [7:0] res;
   logic carry_out, half_carry, carry_to_msb;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;

   ctl_alu u_dut (
      .opa(opa), .opb(opb), .inv_a(inv_a), .inv_b(inv_b),
      .kill_carry(kill_carry), .kill_and(kill_and), .carry_in(carry_in),
      .inv_res(inv_res), .shr(shr), .shl(shl), .res(res),
      .carry_out(carry_out), .half_carry(half_carry), .carry_to_msb(carry_to_msb)
   );

   // code bits: {shl,shr,inv_res,carry_in,kill_and,kill_carry,inv_b,inv_a}
   function automatic logic [7:0] code_lines(input int k);
      case (k)
         0: return 8'h00;  1: return 8'h01;  2: return 8'h02;  3: return 8'h04;
         4: return 8'h08;  5: return 8'h0B;  6: return 8'h10;  7: return 8'h12;
         8: return 8'h20;  9: return 8'h24; 10: return 8'h28; 11: return 8'h2B;
         12: return 8'h40; default: return 8'h80;
      endcase
   endfunction

   function automatic string code_req(input int k);
      case (k)
         0: return "R1"; 1, 2: return "R7"; 3: return "R2"; 4, 5: return "R3";
         6: return "R5"; 7: return "R6"; 8, 9, 10, 11: return "R4";
         default: return "R8";
      endcase
   endfunction

   task automatic apply(input logic [7:0] lines, input int a, input int b);
      {shl, shr, inv_res, carry_in, kill_and, kill_carry, inv_b, inv_a} = lines;
      opa = 8'(a);
      opb = 8'(b);
   endtask

   task automatic check(input string req, input int ex, input int ec, input int eh,
                        input int em, input bit chk_c);
      total++;
      if (res !== 8'(ex) || (chk_c && (carry_out !== 1'(ec) || half_carry !== 1'(eh)
                                        || carry_to_msb !== 1'(em)))) begin
         bad++;
         $display("FAIL %s a=%0d b=%0d act res=%0d c=%0b h=%0b m=%0b exp res=%0d c=%0d h=%0d m=%0d",
                  req, opa, opb, res, carry_out, half_carry, carry_to_msb, ex & 255, ec, eh, em);
      end
   endtask

   initial begin : watchdog
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc == 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog expired act=%0d exp<150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
         end
      end
   end

   initial begin : main
      int ex, ec, eh, em, nb;
      bit cc;
      apply(8'h00, 0, 0);
      #5;
      check("R1", 0, 0, 0, 0, 1'b1);   // idle state: all zero
      for (int k = 0; k < 14; k++) begin
         for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
               apply(code_lines(k), a, b);
               #0.4;
               nb = 255 - b;
               cc = 1'b1; ec = 0; eh = 0; em = 0;
               case (k)
                  0, 8: begin
                     ex = a + b; ec = (a + b) >> 8;
                     eh = ((a & 15) + (b & 15)) > 15;
                     em = ((a & 127) + (b & 127)) > 127;
                     if (k == 8) ex = ~ex;
                  end
                  1: ex = ~a;
                  2: ex = ~b;
                  3: begin ex = a ^ b; cc = 1'b0; end
                  9: begin ex = ~(a ^ b); cc = 1'b0; end
                  4: ex = a | b;
                  5: ex = ~(a & b);
                  10: ex = ~(a | b);
                  11: ex = a & b;
                  6: begin
                     ex = a + 1; ec = (a == 255); eh = ((a & 15) == 15);
                     em = ((a & 127) == 127);
                  end
                  7: begin
                     ex = a + nb + 1; ec = (a >= b); eh = ((a & 15) >= (b & 15));
                     em = ((a & 127) + (nb & 127) + 1) > 127;
                  end
                  12: begin ex = a >> 1; ec = a & 1; end
                  default: begin ex = a << 1; ec = (a >> 7) & 1; end
               endcase
               check(code_req(k), ex, ec, eh, em, cc);
               #0.6;
            end
         end
      end
      // R8: other lines ignored during a single shift
      for (int a = 0; a < 256; a++) begin
         apply(8'h7F, a, 255 - a);
         #0.4;
         check("R8", a >> 1, a & 1, 0, 0, 1'b1);
         #0.6;
         apply(8'hBF, a, a);
         #0.4;
         check("R8", (a << 1) & 255, (a >> 7) & 1, 0, 0, 1'b1);
         #0.6;
         // R9: both shifts hold A
         apply(8'hC0, a, 3);
         #0.4;
         check("R9", a, 0, 0, 0, 1'b1);
         #0.6;
         apply(8'hFF, a, 200);
         #0.4;
         check("R9", a, 0, 0, 0, 1'b1);
         #0.6;
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule